// File: doc/BRIEF.md
# Frame Length Limit Guard

This block sits beside a MAC's frame assembly path and decides, frame by frame, whether the frame is longer than allowed. The limit depends on the frame's direction and on two configuration inputs. With long-frame mode off, a transmit frame may hold at most 1518 bytes. A receive frame may hold 1518 bytes, or 1538 when the extended-receive input is set. With long-frame mode on, the limit in both directions comes from a programmable length register. That register value is clamped to a ceiling fixed when the design is built.

Frames arrive as beats. Each beat carries a byte count and may carry start and end markers. On transmit a beat is one gathered fragment. When a fragment would carry the total past the limit, that fragment and every later fragment of the frame are left out of the running count. On receive the compared length includes the four FCS bytes that follow the payload. The block flags the frame as too long and pulses a bus-error interrupt request tagged with the frame's queue number. It then pulses a drop indication when the frame ends.

Top module: `frame_len_guard`

## Requirements
- R1: With long-frame mode off, the transmit limit is 1518 bytes whether or not the extended-receive input is set.
- R2: With long-frame mode off, the receive limit is 1518 bytes, or 1538 bytes when the extended-receive input is set. The receive length compared against the limit is the payload byte count plus 4.
- R3: With long-frame mode on, the limit in both directions is the smaller of the length register and the ceiling JUMBO_CEIL (default 10240). Receive frames still add 4 bytes.
- R4: A register write stores the written data ANDed with the low LEN_W bits (mask 0x3FFF by default). After reset the register holds JUMBO_CEIL. The register reads back the stored value, unclamped, from the cycle after the write.
- R5: In the cycle after the first beat whose running length exceeds the limit, `err_irq` pulses high for one cycle. `err_queue` then carries the queue number sampled on the frame's start beat. There is at most one pulse per frame.
- R6: `too_long` is high from the cycle after the offending beat through the cycle in which the end beat is presented. It is low in the cycle after the end beat.
- R7: `frame_drop` pulses for one cycle after the end beat of a frame that exceeded its limit, in either direction. It stays low for frames within the limit.
- R8: On transmit, `run_len` stops at the total from before the offending fragment and ignores later fragments. On receive, `run_len` counts every payload byte (no FCS).
- R9: After reset, `too_long`, `err_irq`, `frame_drop` and `run_len` are zero and the length register reads JUMBO_CEIL.
- R10: A frame whose compared length equals the limit exactly is not flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_jumbo_en | input | 1 | Long-frame mode (configuration bit 3) |
| cfg_long_rx | input | 1 | Extended receive limit of 1538 (configuration bit 8) |
| is_tx | input | 1 | Direction of the frame, 1 = transmit; sampled on the start beat |
| frm_queue | input | QID_W | Queue number of the frame; sampled on the start beat |
| beat_valid | input | 1 | A beat is presented this cycle |
| beat_sof | input | 1 | Beat is the first of a frame |
| beat_eof | input | 1 | Beat is the last of a frame |
| beat_bytes | input | SEG_W | Byte count carried by the beat |
| jlen_wr_en | input | 1 | Write strobe for the length register |
| jlen_wr_data | input | REG_W | Write data for the length register |
| jlen_rd_data | output | REG_W | Stored length register value |
| too_long | output | 1 | Current frame has exceeded its limit |
| err_irq | output | 1 | One-cycle bus-error interrupt request |
| err_queue | output | QID_W | Queue for the interrupt request |
| frame_drop | output | 1 | One-cycle drop indication at frame end |
| run_len | output | LEN_W+2 | Running accepted byte count of the current frame |

## Verification
On every cycle the embedded properties check four things. An interrupt pulse never follows a cycle in which the frame was already flagged. A drop pulse always has a flagged frame behind it. The too-long flag falls only after an end or start beat. A flagged transmit frame's running count stays frozen. They also check that the effective long-frame length never exceeds the ceiling, that a write reads back masked, and that without long-frame mode only the two standard limits appear, with 1538 never applied to transmit. Only the directed scenarios can show the limit values themselves for each mode and direction. They also show the off-by-one boundaries at 1518, 1538, a programmed length and the clamped ceiling, and the four FCS bytes on receive. Finally they show the queue tag on the interrupt and the exact number of cycles the flag stays high.

// File: rtl/flen_pkg.sv
`timescale 1ns/1ps
package flen_pkg;
   localparam int STD_LEN   = 1518;
   localparam int EXT_LEN   = 1538;
   localparam int FCS_BYTES = 4;
   typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} dir_e;
endpackage

// File: rtl/flen_jumbo_reg.sv
`timescale 1ns/1ps
module flen_jumbo_reg #(
   parameter int LEN_W      = 14,
   parameter int REG_W      = 32,
   parameter int JUMBO_CEIL = 10240
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic [LEN_W-1:0] eff_len
);
   localparam logic [REG_W-1:0] FIELD_MASK = REG_W'((64'd1 << LEN_W) - 64'd1);
   localparam logic [REG_W-1:0] CEIL_V     = REG_W'(JUMBO_CEIL);

   logic [REG_W-1:0] len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     len_q <= CEIL_V;
      else if (wr_en) len_q <= wr_data & FIELD_MASK;
   end

   assign rd_data = len_q;

   // Clamp only when the ceiling is below what the field can hold.
   generate
      if (JUMBO_CEIL == (1 << LEN_W) - 1) begin : g_noclamp
         assign eff_len = len_q[LEN_W-1:0];
      end else begin : g_clamp
         logic [REG_W-1:0] clamped;
         assign clamped = (len_q > CEIL_V) ? CEIL_V : len_q;
         assign eff_len = clamped[LEN_W-1:0];
      end
   endgenerate

   p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      REG_W'(eff_len) <= CEIL_V);

   p_wr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == ($past(wr_data) & FIELD_MASK));
endmodule

// File: rtl/flen_limit_sel.sv
`timescale 1ns/1ps
module flen_limit_sel
   import flen_pkg::*;
#(
   parameter int LEN_W = 14
) (
   input  logic             jumbo_en,
   input  logic             long_rx,
   input  logic             is_tx,
   input  logic [LEN_W-1:0] jumbo_len,
   output logic [LEN_W-1:0] limit
);
   always_comb begin
      if (jumbo_en)     limit = jumbo_len;
      else if (is_tx)   limit = LEN_W'(STD_LEN);
      else if (long_rx) limit = LEN_W'(EXT_LEN);
      else              limit = LEN_W'(STD_LEN);
   end

   always_comb begin
      if (!jumbo_en) begin
         p_std_limit_r1: assert (limit == LEN_W'(STD_LEN) ||
                                 (!is_tx && limit == LEN_W'(EXT_LEN)));
      end
   end
endmodule

// File: rtl/flen_tracker.sv
`timescale 1ns/1ps
module flen_tracker
   import flen_pkg::*;
#(
   parameter int LEN_W = 14,
   parameter int SEG_W = 11,
   parameter int QID_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat_valid,
   input  logic             beat_sof,
   input  logic             beat_eof,
   input  logic [SEG_W-1:0] beat_bytes,
   input  logic             is_tx,
   input  logic [QID_W-1:0] queue,
   input  logic [LEN_W-1:0] limit,
   output logic             too_long,
   output logic             err_irq,
   output logic [QID_W-1:0] err_queue,
   output logic             frame_drop,
   output logic [LEN_W+1:0] run_len
);
   localparam int CNT_W = LEN_W + 2;
   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q, base, sum_sat;
   logic [SUM_W-1:0] sum_w, cmp_len;
   logic             ovf_q, ovf_eff, over_now, hold;
   dir_e             dir_q, dir_eff;
   logic [QID_W-1:0] q_q, q_eff;

   always_comb begin
      ovf_eff  = beat_sof ? 1'b0 : ovf_q;
      dir_eff  = beat_sof ? dir_e'(is_tx) : dir_q;
      q_eff    = beat_sof ? queue : q_q;
      base     = beat_sof ? '0 : cnt_q;
      sum_w    = {1'b0, base} + SUM_W'(beat_bytes);
      sum_sat  = sum_w[CNT_W] ? '1 : sum_w[CNT_W-1:0];
      cmp_len  = (dir_eff == DIR_TX) ? {1'b0, sum_sat}
                                     : {1'b0, sum_sat} + SUM_W'(FCS_BYTES);
      over_now = beat_valid && !ovf_eff && (cmp_len > SUM_W'(limit));
      hold     = (dir_eff == DIR_TX) && (ovf_eff || over_now);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         ovf_q      <= 1'b0;
         dir_q      <= DIR_RX;
         q_q        <= '0;
         err_irq    <= 1'b0;
         err_queue  <= '0;
         frame_drop <= 1'b0;
      end else begin
         err_irq    <= over_now;
         frame_drop <= beat_valid && beat_eof && (ovf_eff || over_now);
         if (over_now) err_queue <= q_eff;
         if (beat_valid) begin
            dir_q <= dir_eff;
            q_q   <= q_eff;
            cnt_q <= hold ? base : sum_sat;
            ovf_q <= beat_eof ? 1'b0 : (ovf_eff || over_now);
         end
      end
   end

   assign too_long = ovf_q;
   assign run_len  = cnt_q;

   p_irq_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> (!$past(too_long) || $past(beat_valid && beat_sof)));

   p_drop_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> (err_irq || $past(too_long)));

   p_flag_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(too_long) |-> $past(beat_valid && (beat_eof || beat_sof)));

   p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (too_long && dir_q == DIR_TX && !(beat_valid && beat_sof)) |=> $stable(run_len));
endmodule

// File: rtl/frame_len_guard.sv
`timescale 1ns/1ps
module frame_len_guard #(
   parameter int LEN_W      = 14,
   parameter int SEG_W      = 11,
   parameter int QID_W      = 3,
   parameter int REG_W      = 32,
   parameter int JUMBO_CEIL = 10240
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_jumbo_en,
   input  logic             cfg_long_rx,
   input  logic             is_tx,
   input  logic [QID_W-1:0] frm_queue,
   input  logic             beat_valid,
   input  logic             beat_sof,
   input  logic             beat_eof,
   input  logic [SEG_W-1:0] beat_bytes,
   input  logic             jlen_wr_en,
   input  logic [REG_W-1:0] jlen_wr_data,
   output logic [REG_W-1:0] jlen_rd_data,
   output logic             too_long,
   output logic             err_irq,
   output logic [QID_W-1:0] err_queue,
   output logic             frame_drop,
   output logic [LEN_W+1:0] run_len
);
   generate
      if (JUMBO_CEIL >= (1 << LEN_W)) begin : g_bad_ceil
         $error("JUMBO_CEIL does not fit in LEN_W bits");
      end
      if (JUMBO_CEIL < flen_pkg::EXT_LEN) begin : g_bad_floor
         $error("JUMBO_CEIL below the standard limits");
      end
      if (SEG_W > LEN_W + 1 || REG_W < LEN_W) begin : g_bad_width
         $error("SEG_W or REG_W out of range");
      end
   endgenerate

   logic [LEN_W-1:0] jumbo_len, limit, lim_dir_sel;
   logic             dir_now;

   // Direction for the limit: live on a start beat, otherwise the held one.
   logic dir_hold_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       dir_hold_q <= 1'b0;
      else if (beat_valid && beat_sof)  dir_hold_q <= is_tx;
   end
   assign dir_now = beat_sof ? is_tx : dir_hold_q;

   flen_jumbo_reg #(.LEN_W(LEN_W), .REG_W(REG_W), .JUMBO_CEIL(JUMBO_CEIL)) u_jreg (
      .clk(clk), .rst_n(rst_n), .wr_en(jlen_wr_en), .wr_data(jlen_wr_data),
      .rd_data(jlen_rd_data), .eff_len(jumbo_len));

   flen_limit_sel #(.LEN_W(LEN_W)) u_lim (
      .jumbo_en(cfg_jumbo_en), .long_rx(cfg_long_rx), .is_tx(dir_now),
      .jumbo_len(jumbo_len), .limit(lim_dir_sel));
   assign limit = lim_dir_sel;

   flen_tracker #(.LEN_W(LEN_W), .SEG_W(SEG_W), .QID_W(QID_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_sof(beat_sof),
      .beat_eof(beat_eof), .beat_bytes(beat_bytes), .is_tx(is_tx),
      .queue(frm_queue), .limit(limit), .too_long(too_long), .err_irq(err_irq),
      .err_queue(err_queue), .frame_drop(frame_drop), .run_len(run_len));
endmodule

// File: tb/frame_len_guard_bench.sv
`timescale 1ns/1ps
module frame_len_guard_bench;
   localparam int LEN_W = 14, SEG_W = 11, QID_W = 3, REG_W = 32, CEIL = 10240;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_jumbo_en = 0, cfg_long_rx = 0, is_tx = 0;
   logic [QID_W-1:0] frm_queue = '0;
   logic beat_valid = 0, beat_sof = 0, beat_eof = 0;
   logic [SEG_W-1:0] beat_bytes = '0;
   logic jlen_wr_en = 0;
   logic [REG_W-1:0] jlen_wr_data = '0, jlen_rd_data;
   logic too_long, err_irq, frame_drop;
   logic [QID_W-1:0] err_queue;
   logic [LEN_W+1:0] run_len;

   int n_chk = 0, n_fail = 0;
   int jreg_m = CEIL;
   bit mon_en = 0;
   int m_irq, m_drop, m_tl, m_q;

   always #2.5 clk = ~clk;

   frame_len_guard #(.LEN_W(LEN_W), .SEG_W(SEG_W), .QID_W(QID_W), .REG_W(REG_W),
                     .JUMBO_CEIL(CEIL)) u_frame_len_guard (
      .clk(clk), .rst_n(rst_n), .cfg_jumbo_en(cfg_jumbo_en), .cfg_long_rx(cfg_long_rx),
      .is_tx(is_tx), .frm_queue(frm_queue), .beat_valid(beat_valid), .beat_sof(beat_sof),
      .beat_eof(beat_eof), .beat_bytes(beat_bytes), .jlen_wr_en(jlen_wr_en),
      .jlen_wr_data(jlen_wr_data), .jlen_rd_data(jlen_rd_data), .too_long(too_long),
      .err_irq(err_irq), .err_queue(err_queue), .frame_drop(frame_drop), .run_len(run_len));

   always @(negedge clk) begin
      if (mon_en) begin
         if (err_irq) begin m_irq++; m_q = int'(err_queue); end
         if (frame_drop) m_drop++;
         if (too_long) m_tl++;
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic int exp_limit(bit tx);
      if (cfg_jumbo_en) return (jreg_m > CEIL) ? CEIL : jreg_m;
      if (tx) return 1518;
      return cfg_long_rx ? 1538 : 1518;
   endfunction

   task automatic write_jlen(string tag, int unsigned data);
      @(negedge clk);
      jlen_wr_en = 1; jlen_wr_data = data;
      @(negedge clk);
      jlen_wr_en = 0;
      jreg_m = int'(data & 32'h3FFF);
      chk(tag, "length register readback", int'(jlen_rd_data), jreg_m);
   endtask

   // Sends one frame and checks every observable consequence against the model.
   task automatic run_frame(string tag, bit tx, int q, int total, int seg);
      int lim, cum, off, nb, kept, exp_run;
      lim = exp_limit(tx); cum = 0; off = -1; kept = 0;
      nb = (total + seg - 1) / seg;
      for (int k = 0; k < nb; k++) begin
         int b;
         b = (total - cum < seg) ? total - cum : seg;
         cum += b;
         if (off < 0 && (tx ? cum : cum + 4) > lim) off = k;
         if (off < 0) kept = cum;
      end
      exp_run = tx ? kept : total;
      @(posedge clk);
      m_irq = 0; m_drop = 0; m_tl = 0; m_q = -1; mon_en = 1;
      cum = 0;
      for (int k = 0; k < nb; k++) begin
         @(negedge clk);
         beat_valid = 1; beat_sof = (k == 0); beat_eof = (k == nb - 1);
         beat_bytes = SEG_W'((total - cum < seg) ? total - cum : seg);
         cum += (total - cum < seg) ? total - cum : seg;
         is_tx = (k == 0) ? tx : ~tx;        // direction only matters on the start beat
         frm_queue = QID_W'((k == 0) ? q : q + 1);
      end
      @(negedge clk);
      beat_valid = 0; beat_sof = 0; beat_eof = 0; beat_bytes = '0;
      repeat (3) @(negedge clk);
      @(posedge clk);
      mon_en = 0;
      #1;
      chk(tag, "interrupt pulses", m_irq, (off >= 0) ? 1 : 0);
      chk(tag, "drop pulses (R7)", m_drop, (off >= 0) ? 1 : 0);
      chk(tag, "too_long cycles (R6)", m_tl, (off >= 0) ? nb - 1 - off : 0);
      if (off >= 0) chk(tag, "interrupt queue (R5)", m_q, q);
      chk(tag, "run_len (R8)", int'(run_len), exp_run);
      chk(tag, "too_long after frame", int'(too_long), 0);
   endtask

   task automatic test_reset();
      chk("R9", "too_long", int'(too_long), 0);
      chk("R9", "err_irq", int'(err_irq), 0);
      chk("R9", "frame_drop", int'(frame_drop), 0);
      chk("R9", "run_len", int'(run_len), 0);
      chk("R9", "length register", int'(jlen_rd_data), CEIL);
   endtask

   task automatic test_tx_standard();
      cfg_jumbo_en = 0; cfg_long_rx = 1;      // R1: extended receive bit has no effect on transmit
      run_frame("R10", 1, 1, 1518, 500);
      run_frame("R1", 1, 2, 1519, 500);
      run_frame("R1", 1, 3, 1530, 400);
   endtask

   task automatic test_tx_fragments();
      cfg_jumbo_en = 0; cfg_long_rx = 0;
      run_frame("R8", 1, 5, 3000, 1000);      // offends on second fragment
      run_frame("R6", 1, 6, 2400, 300);
   endtask

   task automatic test_rx();
      cfg_jumbo_en = 0; cfg_long_rx = 0;
      run_frame("R2", 0, 2, 1514, 500);       // 1514 + 4 = 1518, at limit
      run_frame("R2", 0, 4, 1515, 500);
      cfg_long_rx = 1;
      run_frame("R2", 0, 7, 1534, 500);
      run_frame("R2", 0, 0, 1535, 500);
      run_frame("R5", 0, 3, 2000, 400);
   endtask

   task automatic test_jumbo();
      write_jlen("R4", 9000);
      cfg_jumbo_en = 1; cfg_long_rx = 0;
      run_frame("R3", 1, 1, 9000, 1000);
      run_frame("R3", 1, 2, 9001, 1000);
      run_frame("R3", 0, 3, 8996, 1000);
      run_frame("R3", 0, 4, 8997, 1000);
   endtask

   task automatic test_clamp();
      write_jlen("R4", 32'hFFFF_FFFF);         // reads 16383, limit clamped to 10240
      cfg_jumbo_en = 1;
      run_frame("R3", 1, 5, 10240, 1000);
      run_frame("R3", 1, 6, 10241, 1000);
      write_jlen("R4", 32'h1234_5678);         // stored as 0x1678
      chk("R4", "masked value", int'(jlen_rd_data), 32'h1678);
      cfg_jumbo_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      test_reset();
      rst_n = 1;
      repeat (2) @(negedge clk);
      test_reset();
      test_tx_standard();
      test_tx_fragments();
      test_rx();
      test_jumbo();
      test_clamp();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule